// File: doc/BRIEF.md
# Logarithmic Number System Multiplier

This block multiplies two signed numbers held in logarithmic form. Each operand carries a two-bit class code, a sign and a base-2 logarithm stored as a two's-complement fixed-point value with 8 integer and 23 fraction bits. The value is (-1)^sign × 2^log. Because the operands are already logarithms, the product needs no mantissa multiplier. It takes one fixed-point addition of the two logarithms, an XOR of the signs, and a small amount of class logic for zero, infinity and NaN.

An operand pair is presented together with a one-cycle valid strobe. The result appears on the output register on the next clock edge, with its own valid strobe. A logarithm sum that does not fit the field saturates. If it is too large the result is a signed infinity. If it is too small the result is flushed to a signed zero.

Word layout, 34 bits: bits [33:32] class (2'b00 zero, 2'b01 finite, 2'b10 infinity, 2'b11 NaN), bit [31] sign (1 = negative), bits [30:0] logarithm (two's complement, scaled by 2^23).

Top module: `lns_multiplier`

## Requirements
- R1: For two finite operands whose logarithm sum lies in [-2^30, 2^30-1] (raw), the result has class 2'b01, sign bit [31] equal to the XOR of the operand signs, and logarithm bits [30:0] equal to the sum of the operand logarithms.
- R2: For two finite operands whose logarithm sum exceeds 2^30-1 (raw), the result is infinity (class 2'b10) with the XOR of the signs and logarithm bits all zero. A sum of exactly 2^30-1 stays finite.
- R3: For two finite operands whose logarithm sum is below -2^30 (raw), the result is zero (class 2'b00) with the XOR of the signs and logarithm bits all zero. A sum of exactly -2^30 stays finite.
- R4: If either operand has class 2'b11, the result is NaN (class 2'b11) with sign 0 and logarithm 0, whatever the other operand holds.
- R5: Zero (class 2'b00) times infinity (class 2'b10), in either operand order, gives NaN with sign 0 and logarithm 0.
- R6: Zero times zero or zero times a finite value gives zero with the XOR of the signs and logarithm 0. The logarithm bits of a zero or infinite operand have no effect on the result.
- R7: Infinity times infinity or infinity times a finite value gives infinity with the XOR of the signs and logarithm 0.
- R8: out_valid is high exactly in the cycle after a cycle with in_valid high. result changes only on an edge where in_valid is high, and holds its value otherwise.
- R9: While rst is high at a clock edge, out_valid and result are cleared to zero on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand strobe |
| op_a | input | 34 | First operand word |
| op_b | input | 34 | Second operand word |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| result | output | 34 | Registered product word |

## Verification
Two functions of this block can meet in the same cycle: saturation of the logarithm sum, and the special-class precedence. The bench provokes this with a NaN operand paired with a finite operand at the top of the logarithm range, and with zero and infinity operands whose ignored logarithm bits would overflow if they were added. It judges each case by requiring the class result (NaN, zero or infinity with logarithm zero) rather than a saturated finite sum. Back-to-back strobes also place a new capture in the same cycle as the previous result's presentation, and the bench checks both products in order.

// File: rtl/lnsm_pkg.sv
package lnsm_pkg;

    parameter int INT_W  = 8;
    parameter int FRAC_W = 23;

    localparam int LOG_W = INT_W + FRAC_W;
    localparam int CLS_W = 2;
    localparam int OP_W  = CLS_W + 1 + LOG_W;

    typedef enum logic [CLS_W-1:0] {
        CLS_ZERO = 2'b00,
        CLS_FIN  = 2'b01,
        CLS_INF  = 2'b10,
        CLS_NAN  = 2'b11
    } lns_cls_e;

    typedef struct packed {
        lns_cls_e          cls;
        logic              sgn;
        logic [LOG_W-1:0]  lg;
    } lns_word_t;

    // Build a non-finite word; its logarithm field is always cleared.
    function automatic lns_word_t make_special(lns_cls_e c, logic s);
        lns_word_t w;
        w.cls = c;
        w.sgn = (c == CLS_NAN) ? 1'b0 : s;
        w.lg  = '0;
        return w;
    endfunction

endpackage

// File: rtl/lnsm_log_adder.sv
module lnsm_log_adder
    import lnsm_pkg::*;
#(
    parameter int W = LOG_W
) (
    input  logic [W-1:0] a_lg,
    input  logic [W-1:0] b_lg,
    output logic [W-1:0] sum_lg,
    output logic         too_big,
    output logic         too_small
);
    localparam int EW = W + 1;

    logic [EW-1:0] wide;

    always_comb begin
        wide      = {a_lg[W-1], a_lg} + {b_lg[W-1], b_lg};
        sum_lg    = wide[W-1:0];
        // Guard bit and top bit disagree: the sum left the field range.
        too_big   = !wide[EW-1] &&  wide[W-1];
        too_small =  wide[EW-1] && !wide[W-1];
    end
endmodule

// File: rtl/lnsm_resolve.sv
module lnsm_resolve
    import lnsm_pkg::*;
(
    input  lns_cls_e          a_cls,
    input  lns_cls_e          b_cls,
    input  logic              a_sgn,
    input  logic              b_sgn,
    input  logic [LOG_W-1:0]  sum_lg,
    input  logic              too_big,
    input  logic              too_small,
    output lns_word_t         prod
);
    logic s_x;
    logic any_nan, any_inf, any_zero;

    always_comb begin
        s_x      = a_sgn ^ b_sgn;
        any_nan  = (a_cls == CLS_NAN)  || (b_cls == CLS_NAN);
        any_inf  = (a_cls == CLS_INF)  || (b_cls == CLS_INF);
        any_zero = (a_cls == CLS_ZERO) || (b_cls == CLS_ZERO);

        if (any_nan || (any_inf && any_zero)) begin
            prod = make_special(CLS_NAN, 1'b0);
        end else if (any_inf) begin
            prod = make_special(CLS_INF, s_x);
        end else if (any_zero) begin
            prod = make_special(CLS_ZERO, s_x);
        end else if (too_big) begin
            prod = make_special(CLS_INF, s_x);
        end else if (too_small) begin
            prod = make_special(CLS_ZERO, s_x);
        end else begin
            prod.cls = CLS_FIN;
            prod.sgn = s_x;
            prod.lg  = sum_lg;
        end
    end
endmodule

// File: rtl/lnsm_out_stage.sv
module lnsm_out_stage
    import lnsm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  lns_word_t  d,
    output lns_word_t  q,
    output logic       q_vld
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q     <= '0;
            q_vld <= 1'b0;
        end else begin
            q_vld <= load;
            if (load) begin
                q <= d;
            end
        end
    end
endmodule

// File: rtl/lns_multiplier.sv
module lns_multiplier
    import lnsm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [OP_W-1:0]  op_a,
    input  logic [OP_W-1:0]  op_b,
    output logic             out_valid,
    output logic [OP_W-1:0]  result
);
    lns_word_t    a_w, b_w, prod_w, res_w;
    logic [LOG_W-1:0] sum_lg;
    logic         too_big, too_small;

    assign a_w = lns_word_t'(op_a);
    assign b_w = lns_word_t'(op_b);

    lnsm_log_adder #(.W(LOG_W)) adder_i (
        .a_lg      (a_w.lg),
        .b_lg      (b_w.lg),
        .sum_lg    (sum_lg),
        .too_big   (too_big),
        .too_small (too_small)
    );

    lnsm_resolve resolve_i (
        .a_cls     (a_w.cls),
        .b_cls     (b_w.cls),
        .a_sgn     (a_w.sgn),
        .b_sgn     (b_w.sgn),
        .sum_lg    (sum_lg),
        .too_big   (too_big),
        .too_small (too_small),
        .prod      (prod_w)
    );

    lnsm_out_stage out_i (
        .clk   (clk),
        .rst   (rst),
        .load  (in_valid),
        .d     (prod_w),
        .q     (res_w),
        .q_vld (out_valid)
    );

    assign result = res_w;
endmodule

// File: rtl/lns_mul_checker.sv
module lns_mul_checker
    import lnsm_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [OP_W-1:0]  op_a,
    input logic [OP_W-1:0]  op_b,
    input logic             out_valid,
    input logic [OP_W-1:0]  result
);
    localparam int CT = OP_W - 1;
    localparam int SB = LOG_W;

    logic a_nan, b_nan, a_fin, b_fin, zi_pair;
    logic signed [LOG_W:0] ref_sum;
    logic ref_big, ref_small;

    always_comb begin
        a_nan   = op_a[CT -: 2] == 2'b11;
        b_nan   = op_b[CT -: 2] == 2'b11;
        a_fin   = op_a[CT -: 2] == 2'b01;
        b_fin   = op_b[CT -: 2] == 2'b01;
        zi_pair = (op_a[CT -: 2] == 2'b00 && op_b[CT -: 2] == 2'b10) ||
                  (op_a[CT -: 2] == 2'b10 && op_b[CT -: 2] == 2'b00);
        ref_sum = $signed({op_a[LOG_W-1], op_a[LOG_W-1:0]}) +
                  $signed({op_b[LOG_W-1], op_b[LOG_W-1:0]});
        ref_big   = ref_sum >  $signed({2'b00, {(LOG_W-1){1'b1}}});
        ref_small = ref_sum <  $signed({2'b11, {(LOG_W-1){1'b0}}});
    end

    // R8: strobe latency of one cycle
    p_valid_follows_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_valid_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));

    // R4 and R5: NaN outcomes
    p_nan_in_r4: assert property (@(posedge clk) disable iff (rst)
        in_valid && (a_nan || b_nan) |=> result == {2'b11, 1'b0, {LOG_W{1'b0}}});
    p_zero_inf_r5: assert property (@(posedge clk) disable iff (rst)
        in_valid && zi_pair |=> result[CT -: 2] == 2'b11);

    // R1: finite product sign is the XOR of the operand signs
    p_sign_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid && a_fin && b_fin |=> result[SB] == ($past(op_a[SB]) ^ $past(op_b[SB])));

    // R2 and R3: saturation direction
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid && a_fin && b_fin && ref_big |=> result[CT -: 2] == 2'b10);
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (rst)
        in_valid && a_fin && b_fin && ref_small |=> result[CT -: 2] == 2'b00);

    // R6/R7: any non-finite result carries a cleared logarithm
    p_special_log_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid && result[CT -: 2] != 2'b01 |-> result[LOG_W-1:0] == '0);
endmodule

bind lns_multiplier lns_mul_checker chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/lns_multiplier_tb_top.sv
`timescale 1ns/1ps
module lns_multiplier_tb_top;
    localparam int W  = 34;
    localparam int NV = 15;

    localparam logic [1:0] CZ = 2'b00, CF = 2'b01, CI = 2'b10, CN = 2'b11;

    // each entry: {op_a, op_b, expected}
    localparam logic [3*W-1:0] VEC [NV] = '{
        {CF,1'b0,31'h00800000, CF,1'b0,31'h01000000, CF,1'b0,31'h01800000}, // R1 1+2
        {CF,1'b1,31'h00800000, CF,1'b0,31'h7E800000, CF,1'b1,31'h7F000000}, // R1 1+(-3)
        {CF,1'b0,31'h3FFFFFFF, CF,1'b0,31'h00000001, CI,1'b0,31'h00000000}, // R2 just over
        {CF,1'b1,31'h3FFFFFFF, CF,1'b0,31'h3FFFFFFF, CI,1'b1,31'h00000000}, // R2 negative inf
        {CF,1'b0,31'h3FFFFFFF, CF,1'b1,31'h00000000, CF,1'b1,31'h3FFFFFFF}, // R2 exact max stays finite
        {CF,1'b0,31'h40000000, CF,1'b0,31'h7FFFFFFF, CZ,1'b0,31'h00000000}, // R3 just under
        {CF,1'b1,31'h40000000, CF,1'b0,31'h40000000, CZ,1'b1,31'h00000000}, // R3 signed zero
        {CF,1'b0,31'h40000000, CF,1'b0,31'h00000000, CF,1'b0,31'h40000000}, // R3 exact min stays finite
        {CN,1'b1,31'h3FFFFFFF, CF,1'b0,31'h3FFFFFFF, CN,1'b0,31'h00000000}, // R4 NaN beats overflow
        {CI,1'b0,31'h00000000, CN,1'b1,31'h00000005, CN,1'b0,31'h00000000}, // R4 inf x NaN
        {CZ,1'b0,31'h00012345, CI,1'b1,31'h00000000, CN,1'b0,31'h00000000}, // R5 zero x inf
        {CI,1'b1,31'h00000000, CZ,1'b1,31'h00000000, CN,1'b0,31'h00000000}, // R5 inf x zero
        {CZ,1'b1,31'h3FFFFFFF, CF,1'b0,31'h3FFFFFFF, CZ,1'b1,31'h00000000}, // R6 zero log ignored
        {CI,1'b0,31'h40000000, CI,1'b1,31'h40000000, CI,1'b1,31'h00000000}, // R7 inf x inf
        {CI,1'b1,31'h00000000, CF,1'b1,31'h40000000, CI,1'b0,31'h00000000}  // R7 inf x finite
    };
    localparam int VREQ [NV] = '{1,1,2,2,2,3,3,3,4,4,5,5,6,7,7};

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         out_valid;
    logic [W-1:0] result;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2.5 clk = ~clk;

    lns_multiplier dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .op_a      (op_a),
        .op_b      (op_b),
        .out_valid (out_valid),
        .result    (result)
    );

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        logic [W-1:0] held;
        repeat (3) @(negedge clk);
        check("R9 reset valid", {33'b0, out_valid}, '0);
        check("R9 reset result", result, '0);
        rst = 1'b0;

        // Vector table, one strobe at a time
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            op_a = VEC[i][3*W-1 -: W];
            op_b = VEC[i][2*W-1 -: W];
            in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            check($sformatf("R%0d vec%0d", VREQ[i], i), result, VEC[i][W-1:0]);
            check("R8 valid after strobe", {33'b0, out_valid}, 34'd1);
        end

        // R8: idle cycles hold the result while inputs change
        held = result;
        op_a = VEC[0][3*W-1 -: W];
        op_b = VEC[0][2*W-1 -: W];
        @(negedge clk);
        check("R8 idle valid low", {33'b0, out_valid}, '0);
        @(negedge clk);
        check("R8 result held", result, held);

        // R8: back-to-back strobes
        op_a = VEC[1][3*W-1 -: W];
        op_b = VEC[1][2*W-1 -: W];
        in_valid = 1'b1;
        @(negedge clk);
        check("R8 b2b first", result, VEC[1][W-1:0]);
        op_a = VEC[13][3*W-1 -: W];
        op_b = VEC[13][2*W-1 -: W];
        @(negedge clk);
        in_valid = 1'b0;
        check("R8 b2b second", result, VEC[13][W-1:0]);
        check("R8 b2b valid", {33'b0, out_valid}, 34'd1);

        // R9: reset while a result is held
        op_a = VEC[0][3*W-1 -: W];
        op_b = VEC[0][2*W-1 -: W];
        in_valid = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        check("R9 mid reset valid", {33'b0, out_valid}, '0);
        check("R9 mid reset result", result, '0);
        rst = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        check("R1 after reset", result, VEC[0][W-1:0]);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule